// File: doc/BRIEF.md
# Thermal Limit Alert and Shutdown Logic

This block watches a set of temperature channels and drives two active-low flags. Each channel reports a signed 8-bit reading in degrees Celsius. The block compares that reading with a high limit held for that channel. If any channel is above its limit, the alert flag goes low. The shutdown flag goes low only for channels whose link bit is set. A critical threshold, shared by all channels, always pulls both flags low.

A small register file holds the limits, the critical threshold, a configuration byte and a two-bit conversion-rate field. The configuration byte carries:

- a display format bit, which selects plain two's-complement or a copy shifted up by 64;
- one shutdown-link bit per channel;
- a write-once lock bit.

While the lock is set, every configuration register ignores writes and soft resets. Only the hard reset clears it. Temperature readings can be read back in the selected format. Reads return data one cycle after the address is presented.

Top module: `thr_limit_guard`

## Requirements
- R1: After hard reset:
  - every channel limit reads 0x55, the critical threshold reads 0x64, the configuration byte reads 0x00 and the rate register reads 0x02;
  - `alert_n` and `shdn_n` are both 1.
- R2: `alert_n` is 0 in the cycle after any channel exceeds its limit (strictly greater) or the critical threshold. This holds whether or not the channel is linked. Otherwise `alert_n` is 1 in that cycle.
- R3: `shdn_n` is 0 in the cycle after a channel exceeds its limit only when that channel's link bit, at configuration bit 2+channel, is 1. An exceedance on an unlinked channel leaves `shdn_n` at 1 unless another cause is present.
- R4: Configuration bit 1 selects the display format:
  - 0: a temperature address (0x00+channel) reads the raw reading;
  - 1: it reads raw+64, clamped at 0 below −64 °C.
  Limit comparison uses the same format: signed when 0, unsigned when 1.
- R5: The critical threshold (address 0x10) is always compared as a signed two's-complement value against the raw reading. Any channel above it drives `shdn_n` to 0 in the next cycle, whatever the format bit and link bits say.
- R6: The lock is configuration bit 0 (address 0x11). Once it is 1, writes to the limits (0x08+channel), the critical threshold, the configuration byte and the rate register are ignored. Reads still return the stored values, and writing 0 to the lock bit has no effect.
- R7: Only the hard reset `rst_n` clears the lock. A soft reset leaves the lock and all locked registers unchanged.
- R8: While unlocked, `soft_rst` returns every configuration register to its R1 value. If a write arrives in the same cycle as a soft reset, the soft reset wins.
- R9: The rate register (address 0x12) stores `wdata[1:0]`, and its bits 7:2 read as 0.
- R10: `rdata` shows the register at `addr` one cycle later. Unmapped addresses read 0, and writes to temperature addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, synchronous, respects the lock |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| temp_in | input | NUM_CH*DW | Signed readings, channel 0 in the low byte |
| alert_n | output | 1 | Alert flag, active low, registered |
| shdn_n | output | 1 | System shutdown flag, active low, registered |

## Verification
Two same-cycle collisions matter here.

The first is a soft reset and a register write landing on the same edge. The bench raises both strobes together, once with the block unlocked and once locked. Read-back must show either the default value (soft reset won) or the value held under the lock; the written value must never appear.

The second collision happens on every cycle of the temperature sweeps. A reading crosses its limit and also crosses the critical threshold, under each combination of format and link. The bench then judges the alert flag, the shutdown flag and the formatted read-back together against values it computes itself.

// File: rtl/thr_pkg.sv
package thr_pkg;
    // Address map
    localparam logic [7:0] A_TEMP_BASE = 8'h00;
    localparam logic [7:0] A_LIM_BASE  = 8'h08;
    localparam logic [7:0] A_CRIT      = 8'h10;
    localparam logic [7:0] A_CFG       = 8'h11;
    localparam logic [7:0] A_RATE      = 8'h12;

    // Reset values
    localparam logic [7:0] LIM_RST  = 8'h55;
    localparam logic [7:0] CRIT_RST = 8'h64;
    localparam logic [1:0] RATE_RST = 2'b10;

    // Shift applied in the offset display format
    localparam int OFFSET = 64;

    // Configuration byte fields
    localparam int CFG_LOCK = 0;
    localparam int CFG_FMT  = 1;
    localparam int CFG_LINK = 2;
endpackage

// File: rtl/thr_fmt.sv
// Converts one signed reading to the selected display format.
module thr_fmt #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] raw,
    input  logic          fmt_off,
    output logic [DW-1:0] shown
);
    import thr_pkg::*;

    localparam logic signed [DW:0] OFS = OFFSET[DW:0];

    logic signed [DW:0] sum;

    always_comb begin
        sum = $signed({raw[DW-1], raw}) + OFS;
        if (!fmt_off) begin
            shown = raw;
        end else if (sum[DW]) begin
            shown = '0;          // below the offset floor: clamp
        end else begin
            shown = sum[DW-1:0];
        end
    end
endmodule

// File: rtl/thr_regs.sv
// Configuration registers, lock handling and registered read mux.
module thr_regs #(
    parameter int NUM_CH = 3,
    parameter int DW     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic                       wr_en,
    input  logic [7:0]                 addr,
    input  logic [DW-1:0]              wdata,
    input  logic [NUM_CH-1:0][DW-1:0]  shown,
    output logic [DW-1:0]              rdata,
    output logic [NUM_CH-1:0][DW-1:0]  lim,
    output logic [DW-1:0]              crit,
    output logic                       fmt_off,
    output logic [NUM_CH-1:0]          link,
    output logic                       lock,
    output logic [1:0]                 rate
);
    import thr_pkg::*;

    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] lim;
        logic [DW-1:0]             crit;
        logic                      lock;
        logic                      fmt;
        logic [NUM_CH-1:0]         link;
        logic [1:0]                rate;
        logic [DW-1:0]             rdata;
    } st_t;

    localparam st_t RST_ST = '{
        lim:   {NUM_CH{DW'(LIM_RST)}},
        crit:  DW'(CRIT_RST),
        lock:  1'b0,
        fmt:   1'b0,
        link:  '0,
        rate:  RATE_RST,
        rdata: '0
    };

    st_t st_d, st_q;
    logic [DW-1:0] cfg_v;
    logic [DW-1:0] rate_v;

    always_comb begin
        st_d = st_q;

        // Register updates: soft reset has priority, lock blocks both.
        if (soft_rst) begin
            if (!st_q.lock) begin
                st_d.lim  = RST_ST.lim;
                st_d.crit = RST_ST.crit;
                st_d.fmt  = RST_ST.fmt;
                st_d.link = RST_ST.link;
                st_d.rate = RST_ST.rate;
            end
        end else if (wr_en && !st_q.lock) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == A_LIM_BASE + 8'(i)) begin
                    st_d.lim[i] = wdata;
                end
            end
            if (addr == A_CRIT) begin
                st_d.crit = wdata;
            end
            if (addr == A_CFG) begin
                st_d.lock = wdata[CFG_LOCK];
                st_d.fmt  = wdata[CFG_FMT];
                st_d.link = wdata[CFG_LINK +: NUM_CH];
            end
            if (addr == A_RATE) begin
                st_d.rate = wdata[1:0];
            end
        end

        // Read mux (always from the present state)
        cfg_v = '0;
        cfg_v[CFG_LOCK] = st_q.lock;
        cfg_v[CFG_FMT]  = st_q.fmt;
        cfg_v[CFG_LINK +: NUM_CH] = st_q.link;

        rate_v = '0;
        rate_v[1:0] = st_q.rate;

        st_d.rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == A_TEMP_BASE + 8'(i)) begin
                st_d.rdata = shown[i];
            end
            if (addr == A_LIM_BASE + 8'(i)) begin
                st_d.rdata = st_q.lim[i];
            end
        end
        if (addr == A_CRIT) begin
            st_d.rdata = st_q.crit;
        end
        if (addr == A_CFG) begin
            st_d.rdata = cfg_v;
        end
        if (addr == A_RATE) begin
            st_d.rdata = rate_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign lim     = st_q.lim;
    assign crit    = st_q.crit;
    assign fmt_off = st_q.fmt;
    assign link    = st_q.link;
    assign lock    = st_q.lock;
    assign rate    = st_q.rate;
endmodule

// File: rtl/thr_judge.sv
// Per-channel limit and critical comparison, registered flags.
module thr_judge #(
    parameter int NUM_CH = 3,
    parameter int DW     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0][DW-1:0]  raw,
    input  logic [NUM_CH-1:0][DW-1:0]  shown,
    input  logic                       fmt_off,
    input  logic [NUM_CH-1:0][DW-1:0]  lim,
    input  logic [DW-1:0]              crit,
    input  logic [NUM_CH-1:0]          link,
    output logic [NUM_CH-1:0]          over,
    output logic [NUM_CH-1:0]          crit_hit,
    output logic                       alert_n,
    output logic                       shdn_n
);
    typedef struct packed {
        logic alert_n;
        logic shdn_n;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (fmt_off) begin
                over[i] = shown[i] > lim[i];
            end else begin
                over[i] = $signed(raw[i]) > $signed(lim[i]);
            end
            crit_hit[i] = $signed(raw[i]) > $signed(crit);
        end
        fl_d.alert_n = ~((|over) | (|crit_hit));
        fl_d.shdn_n  = ~((|(over & link)) | (|crit_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '{alert_n: 1'b1, shdn_n: 1'b1};
        end else begin
            fl_q <= fl_d;
        end
    end

    assign alert_n = fl_q.alert_n;
    assign shdn_n  = fl_q.shdn_n;
endmodule

// File: rtl/thr_limit_guard.sv
module thr_limit_guard #(
    parameter int NUM_CH = 3,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 wr_en,
    input  logic [7:0]           addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic [NUM_CH*DW-1:0] temp_in,
    output logic                 alert_n,
    output logic                 shdn_n
);
    logic [NUM_CH-1:0][DW-1:0] raw_w;
    logic [NUM_CH-1:0][DW-1:0] shown_w;
    logic [NUM_CH-1:0][DW-1:0] lim_w;
    logic [DW-1:0]             crit_w;
    logic                      fmt_w;
    logic [NUM_CH-1:0]         link_w;
    logic                      lock_w;
    logic [1:0]                rate_w;
    logic [NUM_CH-1:0]         over_w;
    logic [NUM_CH-1:0]         crit_hit_w;

    assign raw_w = temp_in;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_fmt
        thr_fmt #(.DW(DW)) u_fmt (
            .raw     (raw_w[g]),
            .fmt_off (fmt_w),
            .shown   (shown_w[g])
        );
    end

    thr_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .shown    (shown_w),
        .rdata    (rdata),
        .lim      (lim_w),
        .crit     (crit_w),
        .fmt_off  (fmt_w),
        .link     (link_w),
        .lock     (lock_w),
        .rate     (rate_w)
    );

    thr_judge #(.NUM_CH(NUM_CH), .DW(DW)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (raw_w),
        .shown    (shown_w),
        .fmt_off  (fmt_w),
        .lim      (lim_w),
        .crit     (crit_w),
        .link     (link_w),
        .over     (over_w),
        .crit_hit (crit_hit_w),
        .alert_n  (alert_n),
        .shdn_n   (shdn_n)
    );
endmodule

// File: rtl/thr_limit_guard_chk.sv
module thr_limit_guard_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alert_n,
    input logic              shdn_n,
    input logic              lock,
    input logic [1:0]        rate,
    input logic [NUM_CH-1:0] over,
    input logic [NUM_CH-1:0] crit_hit,
    input logic [NUM_CH-1:0] link
);
    AST_ALERT_ON_OVER: assert property (@(posedge clk) disable iff (!rst_n)
        (|over) |=> !alert_n); // R2
    AST_ALERT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|over) && !(|crit_hit)) |=> alert_n); // R2
    AST_SHDN_LINKED: assert property (@(posedge clk) disable iff (!rst_n)
        (|(over & link)) |=> !shdn_n); // R3
    AST_SHDN_WITH_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |-> !alert_n); // R3
    AST_CRIT_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
        (|crit_hit) |=> !shdn_n); // R5
    AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(rate)); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock); // R7
endmodule

bind thr_limit_guard thr_limit_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .alert_n  (alert_n),
    .shdn_n   (shdn_n),
    .lock     (lock_w),
    .rate     (rate_w),
    .over     (over_w),
    .crit_hit (crit_hit_w),
    .link     (link_w)
);

// File: tb/sim_thr_limit_guard.sv
module sim_thr_limit_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            soft_rst = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = 8'h00;
    logic [7:0]      wdata = 8'h00;
    logic [7:0]      rdata;
    logic [NCH*8-1:0] temp_in = '0;
    logic            alert_n;
    logic            shdn_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thr_limit_guard #(.NUM_CH(NCH), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .temp_in(temp_in),
        .alert_n(alert_n), .shdn_n(shdn_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        addr = a; wdata = v; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string req);
        addr = a;
        tick();
        check(req, int'(rdata), exp);
    endtask

    task automatic pulse_soft();
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
    endtask

    function automatic int shown_of(input int raw, input int fmt);
        if (fmt == 0) return raw & 255;
        if (raw + 64 < 0) return 0;
        return raw + 64;
    endfunction

    function automatic int sgn8(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    task automatic check_defaults(input string req);
        for (int c = 0; c < NCH; c++) rd(8'h08 + 8'(c), 8'h55, req);
        rd(8'h10, 8'h64, req);
        rd(8'h11, 8'h00, req);
        rd(8'h12, 8'h02, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        check("R1 alert_n in reset", int'(alert_n), 1);
        check("R1 shdn_n in reset", int'(shdn_n), 1);
        rst_n = 1'b1;
        tick();
        check_defaults("R1 defaults");
        check("R1 alert_n idle", int'(alert_n), 1);
        check("R1 shdn_n idle", int'(shdn_n), 1);

        // R2 R3 R4 R5: sweep channel 0 over all readings, each format and link
        for (int fm = 0; fm < 2; fm++) begin
            for (int lk = 0; lk < 2; lk++) begin
                wr(8'h11, 8'((lk << 2) | (fm << 1)));
                for (int v = 0; v < 256; v++) begin
                    int raw, sh, ov, cr;
                    temp_in = {8'h80, 8'h80, 8'(v)};
                    addr = 8'h00;
                    tick();
                    raw = sgn8(v);
                    sh  = shown_of(raw, fm);
                    ov  = (fm == 0) ? int'(raw > 85) : int'(sh > 85);
                    cr  = int'(raw > 100);
                    check("R4 formatted readback", int'(rdata), sh);
                    check("R2 alert_n", int'(alert_n), ((ov | cr) != 0) ? 0 : 1);
                    check("R3 R5 shdn_n", int'(shdn_n), (((ov & lk) | cr) != 0) ? 0 : 1);
                end
            end
        end

        // R3: every link mask, one hot channel at a time
        temp_in = '0;
        for (int m = 0; m < 8; m++) begin
            wr(8'h11, 8'(m << 2));
            for (int h = 0; h < NCH; h++) begin
                temp_in = '0;
                temp_in[h*8 +: 8] = 8'd90;
                tick();
                check("R3 alert on hot channel", int'(alert_n), 0);
                check("R3 shdn only if linked", int'(shdn_n), ((m >> h) & 1) ? 0 : 1);
            end
            temp_in = '0;
            tick();
            check("R2 alert released", int'(alert_n), 1);
        end

        // R5: raise limits out of reach, crit alone still shuts down
        wr(8'h11, 8'h02);
        for (int c = 0; c < NCH; c++) wr(8'h08 + 8'(c), 8'hFF);
        temp_in = {8'd0, 8'd101, 8'd0};
        tick();
        check("R5 crit in offset format", int'(shdn_n), 0);
        temp_in = {8'd0, 8'd100, 8'd0};
        tick();
        check("R5 at crit not over", int'(shdn_n), 1);
        temp_in = '0;

        // R9 R10
        wr(8'h12, 8'hFF);
        rd(8'h12, 8'h03, "R9 rate field");
        rd(8'h30, 8'h00, "R10 unmapped reads zero");
        wr(8'h11, 8'h00);
        temp_in = {8'd0, 8'd0, 8'd33};
        wr(8'h00, 8'h77);
        rd(8'h00, 33, "R10 temperature write ignored");

        // R8: soft reset unlocked, and collision with write
        wr(8'h09, 8'h33);
        rd(8'h09, 8'h33, "R8 limit written");
        pulse_soft();
        check_defaults("R8 soft reset defaults");
        addr = 8'h09; wdata = 8'h22; wr_en = 1'b1; soft_rst = 1'b1;
        tick();
        wr_en = 1'b0; soft_rst = 1'b0;
        rd(8'h09, 8'h55, "R8 soft reset beats write");

        // R6: lock and try to change everything
        wr(8'h0A, 8'h40);
        wr(8'h12, 8'h01);
        wr(8'h10, 8'h70);
        wr(8'h11, 8'h15);
        rd(8'h11, 8'h15, "R6 lock set");
        wr(8'h0A, 8'h10);
        wr(8'h10, 8'h10);
        wr(8'h12, 8'h03);
        wr(8'h11, 8'h00);
        rd(8'h0A, 8'h40, "R6 locked limit");
        rd(8'h10, 8'h70, "R6 locked crit");
        rd(8'h12, 8'h01, "R6 locked rate");
        rd(8'h11, 8'h15, "R6 lock bit write-once");

        // R7: soft reset (alone and with a write) keeps the lock
        pulse_soft();
        addr = 8'h0A; wdata = 8'h11; wr_en = 1'b1; soft_rst = 1'b1;
        tick();
        wr_en = 1'b0; soft_rst = 1'b0;
        rd(8'h11, 8'h15, "R7 lock survives soft reset");
        rd(8'h0A, 8'h40, "R7 locked limit after soft reset");
        rd(8'h12, 8'h01, "R7 locked rate after soft reset");

        // R7: hard reset clears
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        check_defaults("R7 hard reset unlocks");
        wr(8'h0A, 8'h44);
        rd(8'h0A, 8'h44, "R7 writable after hard reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule